// File: doc/BRIEF.md
# DS3 C-bit Parity Path Monitor

This block produces and checks the parity-related overhead of a DS3 stream that uses the C-bit parity format. It sits beside a framer that owns bit timing. For every bit that moves in either direction, the framer presents a bit strobe, a frame-start flag and a slot code saying what the bit is. On the outgoing side the monitor keeps a running parity over the payload bits of each frame. At the next frame start it supplies that parity for the two P positions and the three CP positions. It also supplies the far-end block error (FEBE) value, the format-identification value and the alarm X value for the framer to insert.

On the incoming side the monitor recomputes the payload parity of each frame. It compares the P bits and a 2-of-3 vote of the CP bits of the following frame against that parity. It keeps saturating counts of P mismatches, CP mismatches and received FEBE reports. A CP mismatch, or a framing error event reported by the framer, makes the next outgoing frame carry an all-zero FEBE triple.

The receive checker is a state machine with three states. RX_IDLE waits for the first frame start. RX_FILL accumulates the first frame, which has no reference. RX_TRACK compares every later frame. Each of the transitions idle-to-fill and fill-to-track is taken on a frame start, and RX_TRACK stays in RX_TRACK. The X value comes from a four-state machine:
- X_SET_OPEN: X is 1 and may change. It moves to X_CLR_HOLD when the defect appears.
- X_CLR_HOLD: X is 0 and may not change. It moves to X_CLR_OPEN on a second tick.
- X_CLR_OPEN: X is 0 and may change. It moves to X_SET_HOLD when the defect clears.
- X_SET_HOLD: X is 1 and may not change. It moves to X_SET_OPEN on a second tick.

Top module: `ds3cp_path_mon`

## Requirements
- R1: After reset, tx_p_bit and tx_cp_bit are 0, tx_febe_bit and tx_x_bit are 1, and all three counters are 0.
- R2: Slot code 0 marks a payload bit; every other code marks overhead. On each accepted transmit frame start (tx_bit_en and tx_sof high together), tx_p_bit and tx_cp_bit both take the XOR of the transmit payload bits accepted since the previous frame start. They hold that value until the next frame start. Cycles with the bit strobe low are ignored.
- R3: tx_aic_bit and tx_feac_bit are always 1.
- R4: In receive frames after the first one, a bit with slot code 2 (P) that differs from the payload parity of the preceding receive frame marks the frame. Each marked frame increments p_err_cnt once, at the next receive frame start.
- R5: The three bits with slot code 3 (CP) in a receive frame are combined by a 2-of-3 majority vote. If the vote differs from the parity of the preceding frame, cp_err_cnt increments at the next receive frame start. A single flipped CP bit is not counted.
- R6: A CP mismatch (R5) or a pulse on rx_fram_err makes tx_febe_bit 0 for the next transmit frame started at or after the event. Frames with no such event carry 1.
- R7: If at least two of the bits with slot code 4 (FEBE) in a receive frame are 0, febe_cnt increments at the next receive frame start.
- R8: tx_x_bit is sampled at each transmit frame start. It reflects 0 while rx_defect is high and 1 otherwise. After it changes, it may not change again until a sec_tick pulse has been seen.
- R9: Each counter stops at its all-ones value.
- R10: The first receive frame after reset is never compared, so its P and CP bits cannot raise a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_sof | input | 1 | Transmit bit is the first bit of a frame |
| tx_slot | input | 3 | Transmit slot code (0 payload, else overhead) |
| tx_data | input | 1 | Transmit bit value |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_sof | input | 1 | Receive bit is the first bit of a frame |
| rx_slot | input | 3 | Receive slot code (0 payload, 2 P, 3 CP, 4 FEBE, else other overhead) |
| rx_data | input | 1 | Receive bit value |
| rx_fram_err | input | 1 | Framing error event from the framer |
| rx_defect | input | 1 | Severely errored frame or AIS defect present |
| sec_tick | input | 1 | One pulse per second |
| tx_p_bit | output | 1 | Value for both P positions |
| tx_cp_bit | output | 1 | Value for the three CP positions |
| tx_febe_bit | output | 1 | Value for the three FEBE positions |
| tx_aic_bit | output | 1 | Format identification value |
| tx_feac_bit | output | 1 | Idle value for the alarm channel |
| tx_x_bit | output | 1 | Value for both X positions |
| p_err_cnt | output | CNT_W | Saturating P mismatch count |
| cp_err_cnt | output | CNT_W | Saturating CP mismatch count |
| febe_cnt | output | CNT_W | Saturating received FEBE count |

## Verification
The bench sets the P and CP bits of the first receive frame wrong on purpose. A checker that starts comparing too early would raise counts there. It flips exactly one CP bit, which a design without the majority vote would count, and then two, which must count. Strobe-low cycles carry a frame-start flag and ones in overhead slots. A design that did not gate on the bit strobe, or that folded overhead into parity, would report wrong parity or split frames. The X sequence holds a defect change back until a tick arrives, and the counters are driven past all ones. A missing hold or missing saturation would show as an early X change or a counter that wraps to zero.

// File: rtl/ds3cp_pkg.sv
package ds3cp_pkg;
    typedef enum logic [2:0] {
        SLOT_PAY  = 3'd0,
        SLOT_OH   = 3'd1,
        SLOT_P    = 3'd2,
        SLOT_CP   = 3'd3,
        SLOT_FEBE = 3'd4
    } slot_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_FILL  = 2'd1,
        RX_TRACK = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        X_SET_OPEN = 2'd0,
        X_SET_HOLD = 2'd1,
        X_CLR_OPEN = 2'd2,
        X_CLR_HOLD = 2'd3
    } x_state_e;

    localparam int N_RX_CNT = 3;
endpackage

// File: rtl/ds3cp_par_acc.sv
module ds3cp_par_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sof,
    input  logic is_pay,
    input  logic din,
    output logic run_par
);
    // At a frame start the register still holds the finished parity of the
    // previous frame; the frame-start bit itself is overhead.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_par <= 1'b0;
        end else if (bit_en) begin
            if (sof) run_par <= is_pay & din;
            else     run_par <= run_par ^ (is_pay & din);
        end
    end
endmodule

// File: rtl/ds3cp_sat_cnt.sv
module ds3cp_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP) |=> (cnt == TOP));
    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
endmodule

// File: rtl/ds3cp_x_ctrl.sv
module ds3cp_x_ctrl
    import ds3cp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic defect,
    input  logic sec_tick,
    output logic x_val
);
    x_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= X_SET_OPEN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            X_SET_OPEN: if (defect)   st_nx = X_CLR_HOLD;
            X_CLR_HOLD: if (sec_tick) st_nx = X_CLR_OPEN;
            X_CLR_OPEN: if (!defect)  st_nx = X_SET_HOLD;
            X_SET_HOLD: if (sec_tick) st_nx = X_SET_OPEN;
            default:                  st_nx = X_SET_OPEN;
        endcase
    end

    always_comb begin
        x_val = (st == X_SET_OPEN) || (st == X_SET_HOLD);
    end

    p_set_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == X_SET_HOLD) |=> x_val);
    p_clr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == X_CLR_HOLD) |=> !x_val);
endmodule

// File: rtl/ds3cp_rx_check.sv
module ds3cp_rx_check
    import ds3cp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sof,
    input  logic [2:0]       slot,
    input  logic             din,
    output logic             cp_evt,
    output logic [CNT_W-1:0] p_cnt,
    output logic [CNT_W-1:0] cp_cnt,
    output logic [CNT_W-1:0] fb_cnt
);
    localparam int VW = 2;

    slot_e     sl;
    rx_state_e st, st_nx;
    logic      run_par, ref_par, p_bad, frame_end;
    logic [VW-1:0] cp_ones, fb_zeros;
    logic [N_RX_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]    cnt_arr [N_RX_CNT];

    assign sl        = slot_e'(slot);
    assign frame_end = bit_en && sof;

    ds3cp_par_acc u_acc (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof(sof),
        .is_pay(sl == SLOT_PAY), .din(din), .run_par(run_par)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (frame_end) begin
            unique case (st)
                RX_IDLE:  st_nx = RX_FILL;
                RX_FILL:  st_nx = RX_TRACK;
                RX_TRACK: st_nx = RX_TRACK;
                default:  st_nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_par  <= 1'b0;
            p_bad    <= 1'b0;
            cp_ones  <= '0;
            fb_zeros <= '0;
        end else if (frame_end) begin
            ref_par  <= run_par;
            p_bad    <= 1'b0;
            cp_ones  <= '0;
            fb_zeros <= '0;
        end else if (bit_en) begin
            if (sl == SLOT_P && st == RX_TRACK && din != ref_par) p_bad <= 1'b1;
            if (sl == SLOT_CP && din && cp_ones != '1)            cp_ones <= cp_ones + 1'b1;
            if (sl == SLOT_FEBE && !din && fb_zeros != '1)        fb_zeros <= fb_zeros + 1'b1;
        end
    end

    always_comb begin
        inc_vec[0] = frame_end && (st == RX_TRACK) && p_bad;
        inc_vec[1] = frame_end && (st == RX_TRACK) && ((cp_ones >= 2'd2) != ref_par);
        inc_vec[2] = frame_end && (st != RX_IDLE) && (fb_zeros >= 2'd2);
        cp_evt     = inc_vec[1];
    end

    for (genvar i = 0; i < N_RX_CNT; i++) begin : g_cnt
        ds3cp_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .cnt(cnt_arr[i])
        );
    end

    assign p_cnt  = cnt_arr[0];
    assign cp_cnt = cnt_arr[1];
    assign fb_cnt = cnt_arr[2];

    p_first_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RX_TRACK) |=> ($stable(p_cnt) && $stable(cp_cnt)));
    p_cnt_on_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(p_cnt) && $stable(cp_cnt) && $stable(fb_cnt)));
endmodule

// File: rtl/ds3cp_path_mon.sv
module ds3cp_path_mon
    import ds3cp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit_en,
    input  logic             tx_sof,
    input  logic [2:0]       tx_slot,
    input  logic             tx_data,
    input  logic             rx_bit_en,
    input  logic             rx_sof,
    input  logic [2:0]       rx_slot,
    input  logic             rx_data,
    input  logic             rx_fram_err,
    input  logic             rx_defect,
    input  logic             sec_tick,
    output logic             tx_p_bit,
    output logic             tx_cp_bit,
    output logic             tx_febe_bit,
    output logic             tx_aic_bit,
    output logic             tx_feac_bit,
    output logic             tx_x_bit,
    output logic [CNT_W-1:0] p_err_cnt,
    output logic [CNT_W-1:0] cp_err_cnt,
    output logic [CNT_W-1:0] febe_cnt
);
    logic tx_run, tx_start, cp_evt, x_now;
    logic par_q, febe_q, x_q, pend_q;

    assign tx_start = tx_bit_en && tx_sof;

    ds3cp_par_acc u_tx_acc (
        .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .sof(tx_sof),
        .is_pay(slot_e'(tx_slot) == SLOT_PAY), .din(tx_data), .run_par(tx_run)
    );

    ds3cp_rx_check #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .sof(rx_sof),
        .slot(rx_slot), .din(rx_data), .cp_evt(cp_evt),
        .p_cnt(p_err_cnt), .cp_cnt(cp_err_cnt), .fb_cnt(febe_cnt)
    );

    ds3cp_x_ctrl u_x (
        .clk(clk), .rst_n(rst_n), .defect(rx_defect),
        .sec_tick(sec_tick), .x_val(x_now)
    );

    // Overhead values for the outgoing frame are frozen at its first bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            febe_q <= 1'b1;
            x_q    <= 1'b1;
            pend_q <= 1'b0;
        end else if (tx_start) begin
            par_q  <= tx_run;
            febe_q <= !(pend_q || cp_evt || rx_fram_err);
            x_q    <= x_now;
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_q || cp_evt || rx_fram_err;
        end
    end

    assign tx_p_bit    = par_q;
    assign tx_cp_bit   = par_q;
    assign tx_febe_bit = febe_q;
    assign tx_x_bit    = x_q;
    assign tx_aic_bit  = 1'b1;
    assign tx_feac_bit = 1'b1;

    p_par_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_start |=> $stable(tx_p_bit));
    p_febe_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_start |=> $stable(tx_febe_bit));
    p_x_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_start |=> $stable(tx_x_bit));
    p_febe_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && cp_evt) |=> !tx_febe_bit);
endmodule

// File: tb/ds3cp_path_mon_tb.sv
module ds3cp_path_mon_tb;
    localparam int CW  = 3;
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit_en = 0, tx_sof = 0, tx_data = 0;
    logic rx_bit_en = 0, rx_sof = 0, rx_data = 0;
    logic [2:0] tx_slot = 0, rx_slot = 0;
    logic rx_fram_err = 0, rx_defect = 0, sec_tick = 0;
    logic tx_p_bit, tx_cp_bit, tx_febe_bit, tx_aic_bit, tx_feac_bit, tx_x_bit;
    logic [CW-1:0] p_err_cnt, cp_err_cnt, febe_cnt;

    always #5 clk = ~clk;

    ds3cp_path_mon #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_bit_en(tx_bit_en), .tx_sof(tx_sof), .tx_slot(tx_slot), .tx_data(tx_data),
        .rx_bit_en(rx_bit_en), .rx_sof(rx_sof), .rx_slot(rx_slot), .rx_data(rx_data),
        .rx_fram_err(rx_fram_err), .rx_defect(rx_defect), .sec_tick(sec_tick),
        .tx_p_bit(tx_p_bit), .tx_cp_bit(tx_cp_bit), .tx_febe_bit(tx_febe_bit),
        .tx_aic_bit(tx_aic_bit), .tx_feac_bit(tx_feac_bit), .tx_x_bit(tx_x_bit),
        .p_err_cnt(p_err_cnt), .cp_err_cnt(cp_err_cnt), .febe_cnt(febe_cnt)
    );

    typedef struct {
        int frame;
        bit p;
        bit febe;
        bit x;
        int pc;
        int cc;
        int fc;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit armed = 0;

    // bench model state
    int  n_sof = 0;
    bit  prev_tx_par = 0, prev_rx_par = 0;
    bit  lf_pbad = 0, lf_cpbad = 0, lf_ferr = 0;
    int  lf_fbz = 0;
    int  e_pc = 0, e_cc = 0, e_fc = 0;
    bit  xm = 1, xmay = 1;

    task automatic check1(input string req, input int act, input int exp, input int fr);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s frame %0d actual %0d expected %0d", req, fr, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: pops one expected item per accepted transmit frame start
    always @(negedge clk) begin
        if (armed) begin
            armed = 0;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check1("R2 p", int'(tx_p_bit), int'(it.p), it.frame);
                check1("R2 cp", int'(tx_cp_bit), int'(it.p), it.frame);
                check1("R6 febe", int'(tx_febe_bit), int'(it.febe), it.frame);
                check1("R8 x", int'(tx_x_bit), int'(it.x), it.frame);
                check1("R4/R9 p_err_cnt", int'(p_err_cnt), it.pc, it.frame);
                check1("R5/R9 cp_err_cnt", int'(cp_err_cnt), it.cc, it.frame);
                check1("R7/R9 febe_cnt", int'(febe_cnt), it.fc, it.frame);
                check1("R3 aic", int'(tx_aic_bit), 1, it.frame);
                check1("R3 feac", int'(tx_feac_bit), 1, it.frame);
            end
        end
        if (rst_n && tx_bit_en && tx_sof) armed = 1;
    end

    task automatic drive_bit(input bit en, input bit sof, input logic [2:0] sl,
                             input bit td, input bit rd, input bit ferr, input bit tick);
        @(posedge clk);
        #2;
        tx_bit_en = en; rx_bit_en = en;
        tx_sof = sof;   rx_sof = sof;
        tx_slot = sl;   rx_slot = sl;
        tx_data = td;   rx_data = rd;
        rx_fram_err = ferr;
        sec_tick = tick;
    endtask

    function automatic void x_step();
        if (xmay && (rx_defect == xm)) begin
            xm = !rx_defect;
            xmay = 0;
        end
    endfunction

    // One bench frame: 0 X(oh), 1 P, 2-4 CP, 5-7 FEBE, 8 P, 9 oh, 10-31 payload.
    task automatic send_frame(input logic [31:0] txs, input logic [31:0] rxs,
                              input int pflip, input int cpflip, input logic [2:0] fb,
                              input bit ferr, input bit dfct, input bit tick);
        exp_t it;
        bit cperr;
        bit refv;
        cperr = 0;
        if (n_sof >= 2) begin
            if (lf_pbad) e_pc = (e_pc < SAT) ? e_pc + 1 : SAT;
            if (lf_cpbad) begin
                e_cc = (e_cc < SAT) ? e_cc + 1 : SAT;
                cperr = 1;
            end
        end
        if (n_sof >= 1 && lf_fbz >= 2) e_fc = (e_fc < SAT) ? e_fc + 1 : SAT;
        it.frame = n_sof;
        it.p     = (n_sof == 0) ? 1'b0 : prev_tx_par;
        it.febe  = !(cperr || lf_ferr);
        it.x     = xm;
        it.pc    = e_pc;
        it.cc    = e_cc;
        it.fc    = e_fc;
        q.push_back(it);

        // reference this frame's P/CP bits should carry (R10: none for frame 0)
        refv     = prev_rx_par;
        lf_pbad  = (n_sof >= 1) && (pflip != 0);
        lf_cpbad = (n_sof >= 1) && (cpflip >= 2);
        lf_ferr  = ferr;
        lf_fbz   = 0;
        for (int k = 0; k < 3; k++) if (!fb[k]) lf_fbz++;

        for (int i = 0; i < 32; i++) begin
            logic [2:0] sl;
            bit rd, td;
            td = 1'b1;
            if (i == 0)                sl = 3'd1;
            else if (i == 1 || i == 8) sl = 3'd2;
            else if (i <= 4)           sl = 3'd3;
            else if (i <= 7)           sl = 3'd4;
            else if (i == 9)           sl = 3'd5;
            else                       sl = 3'd0;
            if (i == 0)                rd = 1'b1;
            else if (i == 1)           rd = refv ^ (pflip != 0);
            else if (i == 8)           rd = refv;
            else if (i <= 4)           rd = refv ^ ((i - 2) < cpflip);
            else if (i <= 7)           rd = fb[i-5];
            else if (i == 9)           rd = 1'b1;
            else begin
                rd = rxs[i];
                td = txs[i];
            end
            drive_bit(1'b1, i == 0, sl, td, rd, ferr && (i == 15), tick && (i == 20));
            if (i == 1) begin
                rx_defect = dfct;
                x_step();
            end
            if (i == 20 && tick) begin
                xmay = 1;
                x_step();
            end
            if (i == 12 || i == 25)
                drive_bit(1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0); // ignored strobe-low cycle
        end
        prev_tx_par = ^txs[31:10];
        prev_rx_par = ^rxs[31:10];
        n_sof++;
    endtask

    function automatic logic [31:0] pat(input int k);
        return (32'(k) * 32'h9E3779B1) ^ (32'(k) << 7) ^ 32'h5A5A1234;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check1("R1 p", int'(tx_p_bit), 0, -1);
        check1("R1 cp", int'(tx_cp_bit), 0, -1);
        check1("R1 febe", int'(tx_febe_bit), 1, -1);
        check1("R1 x", int'(tx_x_bit), 1, -1);
        check1("R1 counters", int'(p_err_cnt) + int'(cp_err_cnt) + int'(febe_cnt), 0, -1);

        // R10: frame 0 carries wrong P and all CP flipped, must not count
        send_frame(pat(1), pat(2), 1, 3, 3'b111, 0, 0, 0);
        send_frame(pat(3), pat(4), 0, 0, 3'b000, 0, 0, 0);   // R7 received FEBE
        send_frame(pat(5), pat(6), 1, 0, 3'b100, 0, 0, 0);   // R4 P error, R7 two zeros
        send_frame(pat(7), pat(8), 0, 1, 3'b110, 0, 0, 0);   // R5 single CP flip not counted
        send_frame(pat(9), pat(10), 0, 2, 3'b111, 0, 0, 0);  // R5 majority flip, R6 febe 0
        send_frame(pat(11), pat(12), 0, 0, 3'b111, 1, 0, 0); // R6 framing error
        send_frame(pat(13), pat(14), 0, 0, 3'b111, 0, 0, 0); // R6 back to 1
        send_frame(pat(15), pat(16), 0, 0, 3'b111, 0, 1, 0); // R8 defect -> X 0
        send_frame(pat(17), pat(18), 0, 0, 3'b111, 0, 0, 0); // R8 held without tick
        send_frame(pat(19), pat(20), 0, 0, 3'b111, 0, 0, 1); // R8 tick releases -> 1
        send_frame(pat(21), pat(22), 0, 0, 3'b111, 0, 1, 0); // R8 held
        send_frame(pat(23), pat(24), 0, 0, 3'b111, 0, 1, 1); // R8 tick -> 0
        for (int f = 0; f < 9; f++)                            // R9 saturation
            send_frame(pat(30 + f), pat(50 + f), 1, 3, 3'b000, 0, 0, 0);
        send_frame(32'h0, 32'hFFFF_FFFF, 0, 0, 3'b111, 0, 0, 0);
        send_frame(32'hFFFF_FC00, 32'h0, 0, 0, 3'b111, 0, 0, 0);
        send_frame(pat(99), pat(98), 0, 0, 3'b111, 0, 0, 0);
        drive_bit(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check1("R2 queue drained", q.size(), 0, n_sof);
        done = 1;
        summary();
        $finish;
    end
endmodule